// File: doc/BRIEF.md
# Predicated Vector Load Address Walker

This block turns one vectorised load command into a stream of scalar memory read requests. A command carries a base address, an element size, an optional scalar stride, a flag that selects indexed addressing with per-lane offsets, a segment count, a vector length and a predicate word with enable and invert controls. When the walker is idle and sees `start`, it captures the whole command. It then issues one request per accepted handshake. Each request carries a byte address, the destination register that receives the data, and the lane (element) index.

Lanes are walked in ascending order. Every enabled lane produces a group of consecutive sub-accesses, one per segment field, and each sub-access targets the next destination register. Unit-stride, constant-stride, indexed and segmented loads all come from the same nested walk. Lanes that the predicate rejects produce no request, so their destination registers are never written. A one-cycle `done` pulse marks the end of each command.

Top module: `vld_addr_walker`

## Requirements
- R1: While `rst_n` is low, and in the first falling-edge sample after `rst_n` is asserted mid-command, `req_valid` and `done` are 0. Any command in progress is abandoned.
- R2: With `stride_sel`=0 the stride equals `elem_size`. A non-indexed lane i starts at offset i*(`seg_len`+1)*stride from `base`.
- R3: With `stride_sel`=1 the stride is taken from `stride_val` in place of `elem_size`.
- R4: With `idx_en`=1 the offset of lane i is bits [i*32 +: 32] of `idx_offs`, and it replaces the product of R2. The segment step still uses the stride.
- R5: An enabled lane issues `seg_len`+1 requests, j = 0..`seg_len`. Request j has address base+offset+j*stride and register (`rd_base`+j) mod 32.
- R6: With `pred_en`=1, lane i is enabled only when (bit i of `pred`) XOR `pred_inv` is 1.
- R7: Lanes at or above `vl` never issue. With `pred_en`=0 every lane below `vl` is enabled. A command with no enabled lane issues no request.
- R8: Requests leave lane by lane in ascending order, and within a lane by ascending j. The walk advances only on a clock edge where `req_valid` and `req_ready` are both 1. Otherwise the request is held unchanged.
- R9: All address arithmetic is 32-bit and wraps modulo 2^32.
- R10: `done` is high for exactly one cycle. That cycle is the one after the edge that accepts the final request, or the one after the capturing edge for a command with no enabled lane. `req_valid` is 0 in that cycle.
- R11: `start` and all command inputs are ignored while a command is in progress. Requests follow the command captured at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture the command when idle |
| base | input | 32 | Base byte address |
| elem_size | input | 32 | Element size in bytes (unit stride) |
| stride_sel | input | 1 | 0: stride is elem_size, 1: stride is stride_val |
| stride_val | input | 32 | Scalar stride in bytes |
| idx_en | input | 1 | Offset register is vectorised (indexed load) |
| idx_offs | input | 256 | Per-lane offsets, lane i at bits [i*32 +: 32] |
| seg_len | input | 3 | Sub-accesses per lane minus one |
| vl | input | 4 | Vector length, 0 to 8 |
| pred | input | 8 | Predicate word, bit i for lane i |
| pred_en | input | 1 | Apply the predicate |
| pred_inv | input | 1 | Invert the predicate before use |
| rd_base | input | 5 | First destination register |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | 32 | Request byte address |
| req_reg | output | 5 | Destination register of the request |
| req_elem | output | 3 | Lane index of the request |
| done | output | 1 | One-cycle end-of-command pulse |

## Verification
The first request of a command is visible in the cycle after the edge that captures `start`. Each following request appears in the cycle after an accepting edge, and `done` is due in the cycle after the edge that takes the last request. The bench drives inputs and samples every output at the falling edge. At each falling edge where `req_valid` and the driven `req_ready` are both high, it compares the request against the next entry of a list built from the requirements. It then checks `done` at exactly the next falling edge and confirms that the pulse is gone one cycle later. Irregular ready patterns leave requests waiting across several cycles, so a walk that advances without a handshake shows up as a miscompare.

// File: rtl/vld_pkg.sv
package vld_pkg;
   typedef enum logic {
      STR_ELEM = 1'b0,
      STR_REG  = 1'b1
   } stride_src_e;
endpackage

// File: rtl/vld_lane_mask.sv
module vld_lane_mask #(
   parameter int MAX_VL = 8,
   parameter int VL_W   = 4
) (
   input  logic [VL_W-1:0]   vl,
   input  logic [MAX_VL-1:0] pred,
   input  logic              pred_en,
   input  logic              pred_inv,
   output logic [MAX_VL-1:0] lane_on
);
   for (genvar g = 0; g < MAX_VL; g++) begin : g_lane
      assign lane_on[g] = (VL_W'(g) < vl) && (!pred_en || (pred[g] ^ pred_inv));
   end
endmodule

// File: rtl/vld_low_pick.sv
module vld_low_pick #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic [N-1:0]  vec,
   output logic [IW-1:0] idx,
   output logic          any
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end
   assign any = |vec;
endmodule

// File: rtl/vld_addr_gen.sv
module vld_addr_gen
   import vld_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int EW     = 3,
   parameter int SEG_W  = 3
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] elem_size,
   input  logic [ADDR_W-1:0] stride_val,
   input  stride_src_e       stride_src,
   input  logic              indexed,
   input  logic [ADDR_W-1:0] idx_off,
   input  logic [EW-1:0]     elem,
   input  logic [SEG_W-1:0]  seg,
   input  logic [SEG_W-1:0]  seg_len,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] stride, seg_cnt, walk_off, lane_off;

   assign stride   = (stride_src == STR_REG) ? stride_val : elem_size;
   assign seg_cnt  = ADDR_W'(seg_len) + ADDR_W'(1);
   assign walk_off = ADDR_W'(elem) * seg_cnt * stride;
   assign lane_off = indexed ? idx_off : walk_off;
   assign addr     = base + lane_off + ADDR_W'(seg) * stride;
endmodule

// File: rtl/vld_addr_walker.sv
module vld_addr_walker
   import vld_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int MAX_VL = 8,
   parameter int SEG_W  = 3,
   parameter int REG_W  = 5,
   localparam int EW    = $clog2(MAX_VL),
   localparam int VL_W  = $clog2(MAX_VL + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [ADDR_W-1:0]        base,
   input  logic [ADDR_W-1:0]        elem_size,
   input  logic                     stride_sel,
   input  logic [ADDR_W-1:0]        stride_val,
   input  logic                     idx_en,
   input  logic [MAX_VL*ADDR_W-1:0] idx_offs,
   input  logic [SEG_W-1:0]         seg_len,
   input  logic [VL_W-1:0]          vl,
   input  logic [MAX_VL-1:0]        pred,
   input  logic                     pred_en,
   input  logic                     pred_inv,
   input  logic [REG_W-1:0]         rd_base,
   output logic                     req_valid,
   input  logic                     req_ready,
   output logic [ADDR_W-1:0]        req_addr,
   output logic [REG_W-1:0]         req_reg,
   output logic [EW-1:0]            req_elem,
   output logic                     done
);
   if (ADDR_W < 8) begin : g_bad_aw
      $error("ADDR_W must be at least 8");
   end
   if (MAX_VL < 2) begin : g_bad_vl
      $error("MAX_VL must be at least 2");
   end
   if (SEG_W < 1 || REG_W < 1) begin : g_bad_fld
      $error("SEG_W and REG_W must be positive");
   end

   logic [ADDR_W-1:0] base_q, esize_q, stride_q;
   stride_src_e       src_q;
   logic              idx_q;
   logic [ADDR_W-1:0] offs_q [MAX_VL];
   logic [SEG_W-1:0]  seg_len_q, seg_q;
   logic [REG_W-1:0]  rd_q;
   logic [MAX_VL-1:0] rem_q, lane_on, rem_after;
   logic [EW-1:0]     cur_elem;
   logic              any_left, accept, last_seg;

   vld_lane_mask #(.MAX_VL(MAX_VL), .VL_W(VL_W)) u_mask (
      .vl(vl), .pred(pred), .pred_en(pred_en), .pred_inv(pred_inv), .lane_on(lane_on)
   );

   vld_low_pick #(.N(MAX_VL), .IW(EW)) u_pick (
      .vec(rem_q), .idx(cur_elem), .any(any_left)
   );

   vld_addr_gen #(.ADDR_W(ADDR_W), .EW(EW), .SEG_W(SEG_W)) u_agen (
      .base(base_q), .elem_size(esize_q), .stride_val(stride_q), .stride_src(src_q),
      .indexed(idx_q), .idx_off(offs_q[cur_elem]), .elem(cur_elem), .seg(seg_q),
      .seg_len(seg_len_q), .addr(req_addr)
   );

   assign req_valid = any_left;
   assign req_elem  = cur_elem;
   assign req_reg   = rd_q + REG_W'(seg_q);
   assign accept    = any_left && req_ready;
   assign last_seg  = (seg_q == seg_len_q);
   assign rem_after = rem_q & ~(MAX_VL'(1) << cur_elem);

   // command capture, only when idle
   always_ff @(posedge clk) begin
      if (!any_left && start) begin
         base_q    <= base;
         esize_q   <= elem_size;
         stride_q  <= stride_val;
         src_q     <= stride_src_e'(stride_sel);
         idx_q     <= idx_en;
         seg_len_q <= seg_len;
         rd_q      <= rd_base;
         for (int i = 0; i < MAX_VL; i++) begin
            offs_q[i] <= idx_offs[i*ADDR_W +: ADDR_W];
         end
      end
   end

   // walk state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         seg_q  <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!any_left) begin
            if (start) begin
               rem_q <= lane_on;
               seg_q <= '0;
               done  <= ~|lane_on;
            end
         end else if (accept) begin
            if (last_seg) begin
               seg_q <= '0;
               rem_q <= rem_after;
               done  <= ~|rem_after;
            end else begin
               seg_q <= seg_q + SEG_W'(1);
            end
         end
      end
   end

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=>
         (req_valid && $stable(req_addr) && $stable(req_reg) && $stable(req_elem)));

   p_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && $past(req_valid)) |-> (req_elem >= $past(req_elem)));

   p_done_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_valid) |-> done);

   p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !req_valid);
endmodule

// File: tb/vld_addr_walker_test.sv
`timescale 1ns/1ps
module vld_addr_walker_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [31:0]  base = '0, elem_size = '0, stride_val = '0;
   logic         stride_sel = 1'b0, idx_en = 1'b0;
   logic [255:0] idx_offs = '0;
   logic [2:0]   seg_len = '0;
   logic [3:0]   vl = '0;
   logic [7:0]   pred = '0;
   logic         pred_en = 1'b0, pred_inv = 1'b0;
   logic [4:0]   rd_base = '0;
   logic         req_valid, req_ready = 1'b0, done;
   logic [31:0]  req_addr;
   logic [4:0]   req_reg;
   logic [2:0]   req_elem;

   always #2.5 clk = ~clk;

   vld_addr_walker uut (
      .clk(clk), .rst_n(rst_n), .start(start), .base(base), .elem_size(elem_size),
      .stride_sel(stride_sel), .stride_val(stride_val), .idx_en(idx_en), .idx_offs(idx_offs),
      .seg_len(seg_len), .vl(vl), .pred(pred), .pred_en(pred_en), .pred_inv(pred_inv),
      .rd_base(rd_base), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_reg(req_reg), .req_elem(req_elem), .done(done)
   );

   typedef struct packed {
      logic [31:0] base;
      logic [31:0] esize;
      logic [31:0] stride;
      logic        csel;
      logic        idx;
      logic [2:0]  seg;
      logic [3:0]  vl;
      logic [7:0]  pred;
      logic        pen;
      logic        pinv;
      logic [4:0]  rd;
      logic [7:0]  rdy;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t TBL [NV] = '{
      '{32'h0000_1000, 32'd4, 32'd0,    1'b0, 1'b0, 3'd0, 4'd8, 8'h00,        1'b0, 1'b0, 5'd0,  8'hFF},        // R2 unit
      '{32'h2000_0000, 32'd8, 32'd0,    1'b0, 1'b0, 3'd2, 4'd5, 8'h00,        1'b0, 1'b0, 5'd3,  8'b1011_0110}, // R5 R8 gaps
      '{32'h0000_8000, 32'd4, 32'h40,   1'b1, 1'b0, 3'd1, 4'd6, 8'b1010_0110, 1'b1, 1'b0, 5'd8,  8'b0110_1101}, // R3 R6
      '{32'h0001_0000, 32'd2, 32'h10,   1'b1, 1'b0, 3'd0, 4'd8, 8'h0F,        1'b1, 1'b1, 5'd1,  8'hFF},        // R6 inverted
      '{32'h0004_0000, 32'd2, 32'd0,    1'b0, 1'b1, 3'd1, 4'd7, 8'hFF,        1'b1, 1'b0, 5'd10, 8'b1100_1011}, // R4 indexed
      '{32'hFFFF_FFF0, 32'd4, 32'h8,    1'b1, 1'b0, 3'd3, 4'd3, 8'h00,        1'b0, 1'b0, 5'd30, 8'hFF},        // R9 wrap
      '{32'h0000_0100, 32'd4, 32'd0,    1'b0, 1'b0, 3'd0, 4'd4, 8'hF0,        1'b1, 1'b0, 5'd0,  8'hFF},        // R7 empty
      '{32'h0000_0200, 32'd4, 32'd0,    1'b0, 1'b0, 3'd1, 4'd0, 8'hFF,        1'b0, 1'b0, 5'd0,  8'hFF},        // R7 vl 0
      '{32'h0000_3000, 32'd4, 32'd3,    1'b1, 1'b1, 3'd2, 4'd8, 8'b0101_0101, 1'b1, 1'b1, 5'd20, 8'b1001_1110}  // R4 R6
   };

   int checks = 0, fails = 0;
   bit finished = 1'b0;
   logic [31:0] exp_addr [64];
   logic [4:0]  exp_reg  [64];
   logic [2:0]  exp_elem [64];
   int n_exp;

   function automatic string tag_of(int v);
      case (v)
         0: return "R2";
         1: return "R5,R8";
         2: return "R3,R6";
         3: return "R6";
         4: return "R4";
         5: return "R9,R5";
         6: return "R7";
         7: return "R7";
         default: return "R4,R6";
      endcase
   endfunction

   function automatic logic [31:0] idx_val(int v, int i);
      return 32'h0000_0100 * i + 32'h13 * (v + 1);
   endfunction

   task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic build(int v);
      vec_t t = TBL[v];
      logic [31:0] st = t.csel ? t.stride : t.esize;
      n_exp = 0;
      for (int i = 0; i < 8; i++) begin
         bit en = (i < int'(t.vl)) && (!t.pen || (t.pred[i] ^ t.pinv));
         if (en) begin
            for (int j = 0; j <= int'(t.seg); j++) begin
               logic [31:0] off = t.idx ? idx_val(v, i) : 32'(i) * (32'(t.seg) + 1) * st;
               exp_addr[n_exp] = t.base + off + 32'(j) * st;
               exp_reg[n_exp]  = t.rd + 5'(j);
               exp_elem[n_exp] = 3'(i);
               n_exp++;
            end
         end
      end
   endtask

   task automatic drive(int v);
      vec_t t = TBL[v];
      base = t.base; elem_size = t.esize; stride_val = t.stride; stride_sel = t.csel;
      idx_en = t.idx; seg_len = t.seg; vl = t.vl; pred = t.pred; pred_en = t.pen;
      pred_inv = t.pinv; rd_base = t.rd;
      for (int i = 0; i < 8; i++) idx_offs[i*32 +: 32] = idx_val(v, i);
   endtask

   // poke >= 1: pulse start with altered inputs while busy (R11)
   task automatic run_vec(int v, int poke, string tag);
      int k = 0, cyc = 0, guard = 0;
      bit poked = 1'b0;
      build(v);
      @(negedge clk);
      drive(v);
      start = 1'b1; req_ready = 1'b0;
      @(negedge clk);
      while (k < n_exp && guard < 400) begin
         if (poke >= 1 && k == poke && !poked) begin
            req_ready = 1'b0; start = 1'b1; base = ~base; vl = 4'd1; stride_val = 32'h77;
            poked = 1'b1;
         end else begin
            start = 1'b0;
            req_ready = TBL[v].rdy[cyc % 8];
         end
         if (req_valid && req_ready) begin
            chk(req_addr == exp_addr[k], tag, "addr", req_addr, exp_addr[k]);
            chk(req_reg == exp_reg[k] && req_elem == exp_elem[k], tag, "reg/elem",
                {19'd0, req_reg, 5'd0, req_elem}, {19'd0, exp_reg[k], 5'd0, exp_elem[k]});
            k++;
         end
         @(negedge clk);
         cyc++; guard++;
      end
      start = 1'b0; req_ready = 1'b0;
      chk(guard < 400, tag, "request count", 32'(k), 32'(n_exp));
      chk(done === 1'b1 && req_valid === 1'b0, "R10", "done after final/empty",
          {30'd0, done, req_valid}, 32'h2);
      @(negedge clk);
      chk(done === 1'b0 && req_valid === 1'b0, "R10", "done single pulse",
          {30'd0, done, req_valid}, 32'h0);
   endtask

   initial begin
      #1;
      chk(req_valid === 1'b0 && done === 1'b0, "R1", "in reset", {30'd0, req_valid, done}, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_valid === 1'b0 && done === 1'b0, "R1", "after reset", {30'd0, req_valid, done}, 0);

      for (int v = 0; v < NV; v++) run_vec(v, 0, tag_of(v));

      // start ignored while busy
      run_vec(2, 2, "R11");
      run_vec(1, 4, "R11");

      // reset mid-command
      @(negedge clk);
      drive(0); start = 1'b1;
      @(negedge clk);
      start = 1'b0; req_ready = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b0; req_ready = 1'b0;
      @(negedge clk);
      chk(req_valid === 1'b0 && done === 1'b0, "R1", "mid-run reset", {30'd0, req_valid, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      run_vec(3, 0, "R1");

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule